// File: doc/BRIEF.md
# Four-Channel Serial Audio Transmitter

This block turns four parallel audio channels into two stereo serial data lines. Both lines share one bit clock and one word-select signal. The bit clock is derived from a master clock running at 256 times the sample rate. Each frame on each line is 64 bit clocks long and holds a left and a right slot of 32 bits each. Samples are up to 20 bits wide, two's complement, and are sent MSB first.

Framing follows one of two formats. In the standard inter-IC sound (I2S) format, word select leads the data by one bit. Line 0 then also carries a 12-bit control word (mute, gain and similar settings) in the slot bits below the sample. In the right-justified format, the sample sits at the end of its slot and the bits ahead of it are filled with sign copies.

Samples, the control word and the format select are all captured once per frame. The block raises a strobe in the master-clock cycle before the capture. A value written at any other time has no effect until the next capture.

Top module: `aud_serial_tx`

## Requirements
- R1: The bit clock runs at one quarter of the master clock. Each bit period is four master cycles: two with the bit clock low, then two with it high.
- R2: In I2S format, word select is low for the left slot (frame bits 0..31) and high for the right slot (bits 32..63). It switches together with the falling bit-clock edge that starts frame bit 0 or bit 32.
- R3: In I2S format, a slot's sample MSB goes out in slot bit 1 and its LSB in slot bit 20. Slot bit 0 carries the last bit of the slot before it. Data changes only on falling bit-clock edges.
- R4: In I2S format on line 0, slot bits 21..32 carry the 12-bit control word, MSB first, in both slots. Slot bit 32 here means bit 0 of the following slot. On line 1 the same positions carry zeros.
- R5: In right-justified format, word select is high for the left slot (frame bits 0..31) and low for the right slot. The sample fills slot bits 12..31, MSB first, and slot bits 0..11 repeat the sample's sign bit. No control word is sent.
- R6: The strobe `frame_load_o` is high for exactly one master cycle, during the last quarter of frame bit 63. On the next clock edge the samples, control word and format are captured. Input changes at any other time have no effect on the frame being sent.
- R7: A format change applied mid-frame first affects word select and data in the frame that follows the next capture.
- R8: While reset is low, the bit clock, word select, strobe and both data lines are held low. The first frame after reset sends zeros on both lines in I2S format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, 256 x sample rate |
| rst_n_i | input | 1 | Synchronous reset, active low |
| fmt_i | input | 1 | Format select: 0 = I2S, 1 = right-justified |
| left_i | input | 2x20 | Left samples, one per line |
| right_i | input | 2x20 | Right samples, one per line |
| ctl_i | input | 12 | Control word placed on line 0 in I2S format |
| bclk_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select |
| sdata_o | output | 2 | Serial data, one bit per line |
| frame_load_o | output | 1 | Capture strobe, one master cycle per frame |

## Verification
A wrong divider or bit count shows up at once as a wrong bit-clock phase or a word-select edge in the wrong bit, within one bit period. A wrong shift register or one-bit delay corrupts the serial word of the very next frame. The bench sees this as a mismatch on a specific bit of one line. A holding or strobe fault shows up as a frame carrying values that were written mid-frame, or a format change landing one frame early. Reset faults show up in the first master cycle after reset goes low.

// File: rtl/aud_tx_pkg.sv
// Shared types for the serial audio transmitter.
package aud_tx_pkg;
    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_RJ  = 1'b1
    } aud_fmt_e;
endpackage

// File: rtl/aud_tx_timing.sv
// Bit clock and frame position generator.
// Divides the master clock by CLK_DIV and counts bits inside a two-slot frame.
// Assumes CLK_DIV is even and at least 4; reset is synchronous, active low.
module aud_tx_timing #(
    parameter int CLK_DIV = 4,
    parameter int SLOT_W  = 32
) (
    input  logic clk_i,
    input  logic rst_n_i,
    output logic run_o,
    output logic bclk_o,
    output logic bit_adv_o,
    output logic frame_end_o,
    output logic left_slot_o
);
    localparam int FRAME_BITS = 2 * SLOT_W;
    localparam int DIV_W      = $clog2(CLK_DIV);
    localparam int BCNT_W     = $clog2(FRAME_BITS);

    logic              run_q;
    logic [DIV_W-1:0]  div_q;
    logic [BCNT_W-1:0] bcnt_q;

    // Count master cycles within a bit and bits within a frame.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            run_q  <= 1'b0;
            div_q  <= '0;
            bcnt_q <= '0;
        end else if (!run_q) begin
            run_q <= 1'b1;
        end else if (div_q == DIV_W'(CLK_DIV - 1)) begin
            div_q <= '0;
            if (bcnt_q == BCNT_W'(FRAME_BITS - 1)) bcnt_q <= '0;
            else                                   bcnt_q <= bcnt_q + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Decode clock phase and frame position.
    always_comb begin
        run_o       = run_q;
        bclk_o      = run_q && (div_q >= DIV_W'(CLK_DIV / 2));
        bit_adv_o   = run_q && (div_q == DIV_W'(CLK_DIV - 1));
        frame_end_o = bit_adv_o && (bcnt_q == BCNT_W'(FRAME_BITS - 1));
        left_slot_o = bcnt_q < BCNT_W'(SLOT_W);
    end

    // R1
    bclk_high_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(bclk_o) |=> bclk_o);

    // R1
    bclk_fall_at_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ($past(rst_n_i) && $fell(bclk_o)) |-> $past(bit_adv_o));
endmodule

// File: rtl/aud_tx_framer.sv
// Builds the 64-bit frame image of each line from the live inputs.
// Left slot sits in the upper half, MSB first. The image is only used at capture.
module aud_tx_framer
    import aud_tx_pkg::*;
#(
    parameter int SAMPLE_W = 20,
    parameter int SLOT_W   = 32,
    parameter int N_LINES  = 2,
    localparam int CTL_W   = SLOT_W - SAMPLE_W
) (
    input  logic                                 fmt_i,
    input  logic [N_LINES-1:0][SAMPLE_W-1:0]     left_i,
    input  logic [N_LINES-1:0][SAMPLE_W-1:0]     right_i,
    input  logic [CTL_W-1:0]                     ctl_i,
    output logic [N_LINES-1:0][2*SLOT_W-1:0]     vec_o
);
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic [CTL_W-1:0]    tail;
        logic [2*SLOT_W-1:0] word;

        // Only line 0 carries the control word.
        if (g == 0) begin : g_ctl
            assign tail = ctl_i;
        end else begin : g_zero
            assign tail = '0;
        end

        // Place the samples according to the selected format.
        always_comb begin
            if (aud_fmt_e'(fmt_i) == FMT_RJ)
                word = {{CTL_W{left_i[g][SAMPLE_W-1]}},  left_i[g],
                        {CTL_W{right_i[g][SAMPLE_W-1]}}, right_i[g]};
            else
                word = {left_i[g], tail, right_i[g], tail};
        end

        assign vec_o[g] = word;
    end
endmodule

// File: rtl/aud_tx_lane.sv
// One serial data line: frame shift register plus the one-bit I2S delay stage.
// Assumes bit_adv_i marks the last master cycle of each bit and load_i marks
// the same cycle at the end of the frame.
module aud_tx_lane #(
    parameter int FRAME_BITS = 64
) (
    input  logic                  clk_i,
    input  logic                  rst_n_i,
    input  logic                  run_i,
    input  logic                  bit_adv_i,
    input  logic                  load_i,
    input  logic                  fmt_rj_i,
    input  logic [FRAME_BITS-1:0] vec_i,
    output logic                  sd_o
);
    logic [FRAME_BITS-1:0] sr_q;
    logic                  dly_q;

    // Load a frame at the strobe, otherwise shift out one bit per bit period.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            sr_q  <= '0;
            dly_q <= 1'b0;
        end else if (load_i) begin
            sr_q  <= vec_i;
            dly_q <= sr_q[FRAME_BITS-1];
        end else if (bit_adv_i) begin
            sr_q  <= {sr_q[FRAME_BITS-2:0], 1'b0};
            dly_q <= sr_q[FRAME_BITS-1];
        end
    end

    // Pick the aligned or the one-bit-delayed stream.
    always_comb begin
        sd_o = run_i && (fmt_rj_i ? sr_q[FRAME_BITS-1] : dly_q);
    end

    // R3
    sd_edge_only_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ($past(rst_n_i) && !$past(bit_adv_i)) |-> $stable(sd_o));

    // R6
    load_on_bit_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        load_i |-> bit_adv_i);
endmodule

// File: rtl/aud_serial_tx.sv
// Top level: two serial data lines sharing one bit clock and one word select.
// Format and frame data are captured together at the frame strobe.
module aud_serial_tx
    import aud_tx_pkg::*;
#(
    parameter int SAMPLE_W = 20,
    parameter int SLOT_W   = 32,
    parameter int N_LINES  = 2,
    parameter int CLK_DIV  = 4,
    localparam int CTL_W   = SLOT_W - SAMPLE_W
) (
    input  logic                             clk_i,
    input  logic                             rst_n_i,
    input  logic                             fmt_i,
    input  logic [N_LINES-1:0][SAMPLE_W-1:0] left_i,
    input  logic [N_LINES-1:0][SAMPLE_W-1:0] right_i,
    input  logic [CTL_W-1:0]                 ctl_i,
    output logic                             bclk_o,
    output logic                             ws_o,
    output logic [N_LINES-1:0]               sdata_o,
    output logic                             frame_load_o
);
    localparam int FRAME_BITS = 2 * SLOT_W;

    logic     run, bit_adv, frame_end, left_slot;
    aud_fmt_e fmt_q;
    logic [N_LINES-1:0][FRAME_BITS-1:0] vec;

    aud_tx_timing #(.CLK_DIV(CLK_DIV), .SLOT_W(SLOT_W)) u_timing (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .run_o      (run),
        .bclk_o     (bclk_o),
        .bit_adv_o  (bit_adv),
        .frame_end_o(frame_end),
        .left_slot_o(left_slot)
    );

    aud_tx_framer #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .N_LINES(N_LINES)) u_framer (
        .fmt_i  (fmt_i),
        .left_i (left_i),
        .right_i(right_i),
        .ctl_i  (ctl_i),
        .vec_o  (vec)
    );

    // Hold the format for the whole frame.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)       fmt_q <= FMT_I2S;
        else if (frame_end) fmt_q <= aud_fmt_e'(fmt_i);
    end

    for (genvar g = 0; g < N_LINES; g++) begin : g_lane
        aud_tx_lane #(.FRAME_BITS(FRAME_BITS)) u_lane (
            .clk_i    (clk_i),
            .rst_n_i  (rst_n_i),
            .run_i    (run),
            .bit_adv_i(bit_adv),
            .load_i   (frame_end),
            .fmt_rj_i (fmt_q == FMT_RJ),
            .vec_i    (vec[g]),
            .sd_o     (sdata_o[g])
        );
    end

    // Word select polarity follows the held format.
    always_comb begin
        ws_o         = run && ((fmt_q == FMT_RJ) ? left_slot : !left_slot);
        frame_load_o = frame_end;
    end

    // R2
    ws_edge_only_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ($past(rst_n_i) && !$past(bit_adv)) |-> $stable(ws_o));

    // R7
    fmt_held_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ($past(rst_n_i) && !$past(frame_load_o)) |-> $stable(fmt_q));

    // R8
    reset_quiet_chk: assert property (@(posedge clk_i)
        !rst_n_i |=> (!bclk_o && !ws_o && (sdata_o == '0) && !frame_load_o));
endmodule

// File: tb/test_aud_serial_tx.sv
// Self-checking bench: directed corner frames, then seeded random frames.
module test_aud_serial_tx;
    localparam int SW = 20;
    localparam int CW = 12;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n;
    logic              fmt;
    logic [1:0][SW-1:0] left, right;
    logic [CW-1:0]     ctl;
    logic              bclk, ws, fl;
    logic [1:0]        sd;

    aud_serial_tx i_aud_serial_tx (
        .clk_i(clk), .rst_n_i(rst_n), .fmt_i(fmt), .left_i(left), .right_i(right),
        .ctl_i(ctl), .bclk_o(bclk), .ws_o(ws), .sdata_o(sd), .frame_load_o(fl)
    );

    int  errs = 0;
    int  checks = 0;
    bit  done = 1'b0;
    logic [1:0] last_bit;
    logic       prev_fmt;

    logic              n_fmt;
    logic [1:0][SW-1:0] n_left, n_right;
    logic [CW-1:0]     n_ctl;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_vec(input logic f, input logic [SW-1:0] l, input logic [SW-1:0] r, input logic [CW-1:0] c);
        if (f) return {{CW{l[SW-1]}}, l, {CW{r[SW-1]}}, r};
        return {l, c, r, c};
    endfunction

    task automatic drive_random();
        fmt   = 1'($urandom);
        left  = {SW'($urandom), SW'($urandom)};
        right = {SW'($urandom), SW'($urandom)};
        ctl   = CW'($urandom);
    endtask

    // Checks one frame; the bench sits just before bit 0 on entry and at the strobe on exit.
    task automatic capture_frame(input logic f, input logic [63:0] v0, input logic [63:0] v1);
        logic [1:0][63:0] v;
        v = {v1, v0};
        for (int b = 0; b < 64; b++) begin
            for (int d = 0; d < 4; d++) begin
                @(negedge clk);
                chk("R1", "bclk", 64'(bclk), 64'(d >= 2));
                if (b == 5 && d == 1) drive_random();
                if (b == 40 && d == 1) begin
                    fmt = n_fmt; left = n_left; right = n_right; ctl = n_ctl;
                end
                if (d == 0 || d == 3) begin
                    for (int i = 0; i < 2; i++) begin
                        logic e;
                        int   k;
                        string rq;
                        k = b % 32;
                        if (f) begin
                            e = v[i][63-b];
                            rq = "R5";
                        end else begin
                            e = (b == 0) ? last_bit[i] : v[i][64-b];
                            rq = (k >= 21 || k == 0) ? "R4" : "R3";
                        end
                        chk(rq, $sformatf("line%0d bit%0d", i, b), 64'(sd[i]), 64'(e));
                    end
                end
                if (d == 2)
                    chk((f != prev_fmt) ? "R7" : (f ? "R5" : "R2"),
                        $sformatf("ws bit%0d", b), 64'(ws), 64'(f ? (b < 32) : (b >= 32)));
                if (d == 3)
                    chk("R6", $sformatf("strobe bit%0d", b), 64'(fl), 64'(b == 63));
            end
        end
        last_bit = {v1[0], v0[0]};
        prev_fmt = f;
    endtask

    task automatic set_next(input int k);
        case (k)
            0: begin n_fmt = 1'b0; n_left = {20'hFFFFF, 20'h80000}; n_right = {20'h00001, 20'h7FFFF}; n_ctl = 12'hFFF; end
            1: begin n_fmt = 1'b1; n_left = {20'hFFFFF, 20'h80000}; n_right = {20'h00001, 20'h7FFFF}; n_ctl = 12'hFFF; end
            2: begin n_fmt = 1'b1; n_left = {20'h12345, 20'h7FFFF}; n_right = {20'hC0000, 20'h00000}; n_ctl = 12'h5A5; end
            3: begin n_fmt = 1'b0; n_left = {20'h0F0F0, 20'hA5A5A}; n_right = {20'h80001, 20'h3C3C3}; n_ctl = 12'hA5C; end
            4: begin n_fmt = 1'b0; n_left = '0; n_right = '0; n_ctl = 12'h000; end
            default: begin
                n_fmt = 1'($urandom); n_left = {SW'($urandom), SW'($urandom)};
                n_right = {SW'($urandom), SW'($urandom)}; n_ctl = CW'($urandom);
            end
        endcase
    endtask

    task automatic run_frames(input int n);
        logic       cf;
        logic [63:0] c0, c1;
        cf = 1'b0; c0 = '0; c1 = '0;
        for (int k = 0; k < n; k++) begin
            set_next(k);
            capture_frame(cf, c0, c1);
            cf = n_fmt;
            c0 = mk_vec(n_fmt, n_left[0], n_right[0], n_ctl);
            c1 = mk_vec(n_fmt, n_left[1], n_right[1], 12'h000);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0A17));
        rst_n = 1'b0; fmt = 1'b1; left = '1; right = '1; ctl = '1;
        last_bit = '0; prev_fmt = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i > 0) chk("R8", "outputs in reset", 64'({bclk, ws, sd, fl}), 64'd0);
        end
        rst_n = 1'b1;
        run_frames(32);
        // Reset in the middle of a frame, then restart from a silent frame.
        repeat (37) @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            drive_random();
            chk("R8", "outputs in mid-run reset", 64'({bclk, ws, sd, fl}), 64'd0);
        end
        last_bit = '0; prev_fmt = 1'b0;
        rst_n = 1'b1;
        run_frames(4);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end
endmodule